// File: doc/BRIEF.md
# Descriptor-List Stream DMA Engine

This block moves audio payload between system memory and a codec for eight stream slots. Slots 0 to 3 carry input (codec to memory) and slots 4 to 7 carry output (memory to codec). Software sets up each slot through a small register port: a control word holding the stream tag, the run bit, a stream-reset bit and a completion flag; the cyclic buffer length; the last valid index; and the base of a buffer descriptor list in memory. Each list entry is 16 bytes: a 64-bit buffer address, a 32-bit byte length and a flags word whose bit 0 asks for an interrupt when the entry is used up.

When the run bit of a slot rises, the engine reads that slot's list over the memory port, one 32-bit word per cycle, and keeps it locally. A codec transfer request then names a stream tag, a direction and a byte count. The engine finds the slot, cuts the transfer into memory bursts that never cross the end of the cyclic buffer or the end of the current descriptor, and moves the link position forward. Completed interrupt-on-completion descriptors raise a sticky flag that halts the slot until software clears it. If enabled, the link position is written back to a position buffer in memory after each request.

Top module: `sdma_engine`

## Requirements
- R1: After reset, every control word and link position reads as zero, `irq` is low and neither `memValid` nor `xferAck` is asserted.
- R2: A 0-to-1 change of control bit 1 (run) makes the engine issue one 4-byte read per cycle for each word of entries 0 to N-1 (N = last valid index + 1, capped at MAX_DESC), at address list base + 16*entry + 4*word in ascending order; the low 7 bits of the written list base are ignored. Word 0 is the low address half, word 1 the high half, word 2 the length, word 3 the flags.
- R3: A request with `xferOut`=1 looks only at slots 4 to 7 and with `xferOut`=0 only at slots 0 to 3; it picks the lowest slot whose control bits 23:20 equal `xferTag`. With no such slot, or a slot that is not running, it is acknowledged with zero bytes moved and no memory traffic.
- R4: Each burst has length min(bytes still requested, cyclic length minus position, descriptor length minus offset in it), address descriptor address plus that offset, `memData`=1, and `memWrite`=1 exactly for input slots.
- R5: The link position (register select 5) advances by each burst length and returns to zero when it reaches the cyclic buffer length.
- R6: When a descriptor is used up, the next burst starts at the following entry, and after entry N-1 at entry 0.
- R7: Using up a descriptor whose flags bit 0 is set sets control bit 26, drives `irq` high and ends the request at once; `xferMoved` then reports the bytes moved so far.
- R8: While control bit 26 of the matched slot is set, a request moves nothing; writing the control word with bit 26 set clears it and `irq` falls.
- R9: When bit 0 of the position-buffer base is set, each request that reached a running slot ends with one 4-byte write of the slot's link position to (base with bit 0 cleared) + 8*slot.
- R10: Writing the control word with bit 0 set clears the slot's position, run bit and bit 26 and keeps its tag.
- R11: A 1-to-0 change of the run bit stops the slot: later requests that match it move zero bytes.
- R12: `xferAck` is a one-cycle pulse, and `xferMoved` is the sum of the burst lengths issued for that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regSlot | input | 3 | Slot addressed by the register port |
| regSel | input | 3 | Register select: 0 control, 1 cyclic length, 2 last index, 3/4 list base low/high, 5 position (read only), 6/7 position-buffer base low/high |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Read data of the selected register |
| xferValid | input | 1 | Transfer request, held until `xferAck` |
| xferTag | input | 4 | Stream tag of the request |
| xferOut | input | 1 | 1 for output (memory to codec), 0 for input |
| xferBytes | input | 32 | Bytes requested |
| xferAck | output | 1 | Request finished |
| xferMoved | output | 32 | Bytes moved for the finished request |
| memValid | output | 1 | Memory command valid this cycle |
| memWrite | output | 1 | 1 write, 0 read |
| memData | output | 1 | 1 payload burst, 0 single 32-bit word access |
| memAddr | output | 64 | Byte address |
| memLen | output | 32 | Byte count |
| memWdata | output | 32 | Word written by a position update |
| memRdata | input | 32 | Read word, valid the cycle after a word read |
| irq | output | 1 | OR of all completion flags |

## Verification
The bench builds the engine with its defaults: eight slots and room for four descriptors per slot. With a three-entry list of 300, 200 and 600 bytes against a 1000-byte cyclic buffer, and a one-entry 64-byte list against a 64-byte buffer, a handful of requests reaches clipping by both limits, position wrap, descriptor wrap, an interrupt stall mid-request and the position-buffer write. A second output slot sharing the tag shows the lowest-slot choice, and tag lookups across the two direction groups show that the groups stay apart.

// File: rtl/sdma_pkg.sv
package sdma_pkg;

  typedef enum logic [2:0] {
    SEL_CTL     = 3'd0,
    SEL_CBL     = 3'd1,
    SEL_LVI     = 3'd2,
    SEL_LIST_LO = 3'd3,
    SEL_LIST_HI = 3'd4,
    SEL_POS     = 3'd5,
    SEL_PBUF_LO = 3'd6,
    SEL_PBUF_HI = 3'd7
  } regSel_e;

  // control -> datapath
  typedef struct packed {
    logic startLoad;
    logic loadStep;
    logic startReq;
    logic segStep;
    logic posWrite;
    logic ack;
  } strobe_t;

  // datapath -> control
  typedef struct packed {
    logic pendAny;
    logic loadLast;
    logic reqHit;
    logic segLast;
    logic posEnable;
  } status_t;

endpackage

// File: rtl/sdma_ctrl.sv
module sdma_ctrl
  import sdma_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    xferValid,
  input  status_t sts,
  output strobe_t stb
);

  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_LWAIT, S_SEG, S_POSW, S_ACK} state_e;
  state_e stateQ, stateD;

  always_comb begin
    stb    = '0;
    stateD = stateQ;
    case (stateQ)
      S_IDLE: begin
        if (sts.pendAny) begin
          stb.startLoad = 1'b1;
          stateD        = S_LOAD;
        end else if (xferValid) begin
          stb.startReq = 1'b1;
          stateD       = sts.reqHit ? S_SEG : S_ACK;
        end
      end
      S_LOAD: begin
        stb.loadStep = 1'b1;
        if (sts.loadLast) stateD = S_LWAIT;
      end
      S_LWAIT: stateD = S_IDLE;
      S_SEG: begin
        stb.segStep = 1'b1;
        if (sts.segLast) stateD = sts.posEnable ? S_POSW : S_ACK;
      end
      S_POSW: begin
        stb.posWrite = 1'b1;
        stateD       = S_ACK;
      end
      S_ACK: begin
        stb.ack = 1'b1;
        stateD  = S_IDLE;
      end
      default: stateD = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= S_IDLE;
    else       stateQ <= stateD;
  end

  // R12: completion is reported for exactly one cycle
  a_r12_ack_pulse: assert property (@(posedge clk) disable iff (!rstN)
    stb.ack |=> !stb.ack);

  // R9: a position update only follows the last burst of a request
  a_r9_pos_after_seg: assert property (@(posedge clk) disable iff (!rstN)
    stb.posWrite |-> $past(stb.segStep));

endmodule

// File: rtl/sdma_path.sv
module sdma_path
  import sdma_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int MAX_DESC  = 4,
  localparam int SLOT_W = $clog2(NUM_SLOTS),
  localparam int IDX_W  = (MAX_DESC > 1) ? $clog2(MAX_DESC) : 1,
  localparam int LD_W   = IDX_W + 2
)(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  output status_t           sts,
  input  logic              regWe,
  input  logic [SLOT_W-1:0] regSlot,
  input  logic [2:0]        regSel,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  logic [3:0]        xferTag,
  input  logic              xferOut,
  input  logic [31:0]       xferBytes,
  output logic [31:0]       xferMoved,
  output logic              memValid,
  output logic              memWrite,
  output logic              memData,
  output logic [63:0]       memAddr,
  output logic [31:0]       memLen,
  output logic [31:0]       memWdata,
  input  logic [31:0]       memRdata,
  output logic              irq
);

  localparam int GROUP = NUM_SLOTS / 2;
  localparam logic [8:0]     MAXN9 = 9'(MAX_DESC);
  localparam logic [IDX_W:0] MAXN  = MAX_DESC[IDX_W:0];

  // per-slot state
  logic [3:0]           tagQ  [NUM_SLOTS];
  logic [31:0]          cblQ  [NUM_SLOTS];
  logic [31:0]          posQ  [NUM_SLOTS];
  logic [31:0]          offQ  [NUM_SLOTS];
  logic [7:0]           lviQ  [NUM_SLOTS];
  logic [63:0]          listQ [NUM_SLOTS];
  logic [IDX_W-1:0]     idxQ  [NUM_SLOTS];
  logic [IDX_W:0]       cntQ  [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] runQ, doneQ, loadedQ, pendQ;
  logic [63:0]          pbufQ;

  // descriptor copies
  logic [63:0]          dAddrQ [NUM_SLOTS][MAX_DESC];
  logic [31:0]          dLenQ  [NUM_SLOTS][MAX_DESC];
  logic [MAX_DESC-1:0]  dIocQ  [NUM_SLOTS];

  // request and load context
  logic [SLOT_W-1:0] reqSlotQ, ldSlotQ;
  logic [31:0]       leftQ, movedQ;
  logic [LD_W-1:0]   ldCntQ, ldLastQ, capCntQ;
  logic              capValidQ;

  // pending-load pick and tag match
  logic [SLOT_W-1:0] pendSel, matchSlot, cand;
  logic              matchFound;
  always_comb begin
    pendSel = '0;
    for (int s = NUM_SLOTS - 1; s >= 0; s--)
      if (pendQ[s]) pendSel = SLOT_W'(s);
    matchFound = 1'b0;
    matchSlot  = '0;
    cand       = '0;
    for (int s = GROUP - 1; s >= 0; s--) begin
      cand = xferOut ? SLOT_W'(s + GROUP) : SLOT_W'(s);
      if (tagQ[cand] == xferTag) begin
        matchFound = 1'b1;
        matchSlot  = cand;
      end
    end
  end

  // list size for the slot about to load
  logic [8:0]      lviPlus;
  logic [IDX_W:0]  nEnt;
  logic [LD_W-1:0] ldLastD;
  always_comb begin
    lviPlus = {1'b0, lviQ[pendSel]} + 9'd1;
    nEnt    = (lviPlus > MAXN9) ? MAXN : lviPlus[IDX_W:0];
    ldLastD = LD_W'({nEnt, 2'b00} - 1'b1);
  end

  // burst sizing
  logic [IDX_W-1:0] curIdx;
  logic [IDX_W:0]   idxInc;
  logic [31:0]      curLen, cblLeft, descLeft, copy, posNext;
  logic [63:0]      curAddr;
  logic             curIoc, descEnd, stall;
  always_comb begin
    curIdx   = idxQ[reqSlotQ];
    idxInc   = {1'b0, curIdx} + 1'b1;
    curLen   = dLenQ[reqSlotQ][curIdx];
    curAddr  = dAddrQ[reqSlotQ][curIdx];
    curIoc   = dIocQ[reqSlotQ][curIdx];
    cblLeft  = cblQ[reqSlotQ] - posQ[reqSlotQ];
    descLeft = curLen - offQ[reqSlotQ];
    copy     = leftQ;
    if (cblLeft < copy)  copy = cblLeft;
    if (descLeft < copy) copy = descLeft;
    posNext  = posQ[reqSlotQ] + copy;
    if (posNext == cblQ[reqSlotQ]) posNext = '0;
    descEnd  = (offQ[reqSlotQ] + copy) == curLen;
    stall    = descEnd && curIoc;
  end

  always_comb begin
    sts.pendAny   = |pendQ;
    sts.loadLast  = (ldCntQ == ldLastQ);
    sts.reqHit    = matchFound && loadedQ[matchSlot] && !doneQ[matchSlot];
    sts.segLast   = (copy == leftQ) || (copy == '0) || stall;
    sts.posEnable = pbufQ[0];
  end

  // memory command
  always_comb begin
    memValid = 1'b0;
    memWrite = 1'b0;
    memData  = 1'b0;
    memAddr  = '0;
    memLen   = '0;
    memWdata = '0;
    if (stb.loadStep) begin
      memValid = 1'b1;
      memAddr  = {listQ[ldSlotQ][63:7], 7'b0} + {{(62 - LD_W){1'b0}}, ldCntQ, 2'b00};
      memLen   = 32'd4;
    end else if (stb.segStep && copy != '0) begin
      memValid = 1'b1;
      memWrite = (reqSlotQ < SLOT_W'(GROUP));
      memData  = 1'b1;
      memAddr  = curAddr + {32'b0, offQ[reqSlotQ]};
      memLen   = copy;
    end else if (stb.posWrite) begin
      memValid = 1'b1;
      memWrite = 1'b1;
      memAddr  = {pbufQ[63:1], 1'b0} + {{(61 - SLOT_W){1'b0}}, reqSlotQ, 3'b000};
      memLen   = 32'd4;
      memWdata = posQ[reqSlotQ];
    end
  end

  // descriptor capture, one word per cycle after each read
  always_ff @(posedge clk) begin
    if (capValidQ) begin
      case (capCntQ[1:0])
        2'd0: dAddrQ[ldSlotQ][capCntQ[LD_W-1:2]][31:0]  <= memRdata;
        2'd1: dAddrQ[ldSlotQ][capCntQ[LD_W-1:2]][63:32] <= memRdata;
        2'd2: dLenQ[ldSlotQ][capCntQ[LD_W-1:2]]         <= memRdata;
        default: dIocQ[ldSlotQ][capCntQ[LD_W-1:2]]      <= memRdata[0];
      endcase
    end
  end

  regSel_e selW;
  assign selW = regSel_e'(regSel);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < NUM_SLOTS; s++) begin
        tagQ[s] <= '0; cblQ[s] <= '0; posQ[s] <= '0; offQ[s] <= '0;
        lviQ[s] <= '0; listQ[s] <= '0; idxQ[s] <= '0; cntQ[s] <= '0;
      end
      runQ <= '0; doneQ <= '0; loadedQ <= '0; pendQ <= '0;
      pbufQ <= '0; reqSlotQ <= '0; ldSlotQ <= '0; leftQ <= '0; movedQ <= '0;
      ldCntQ <= '0; ldLastQ <= '0; capCntQ <= '0; capValidQ <= 1'b0;
    end else begin
      capValidQ <= stb.loadStep;
      capCntQ   <= ldCntQ;
      if (stb.startLoad) begin
        pendQ[pendSel]   <= 1'b0;
        loadedQ[pendSel] <= 1'b1;
        idxQ[pendSel]    <= '0;
        offQ[pendSel]    <= '0;
        cntQ[pendSel]    <= nEnt;
        ldSlotQ          <= pendSel;
        ldCntQ           <= '0;
        ldLastQ          <= ldLastD;
      end
      if (stb.loadStep) ldCntQ <= ldCntQ + 1'b1;
      if (stb.startReq) begin
        reqSlotQ <= matchSlot;
        leftQ    <= xferBytes;
        movedQ   <= '0;
      end
      if (stb.segStep) begin
        posQ[reqSlotQ] <= posNext;
        leftQ          <= leftQ - copy;
        movedQ         <= movedQ + copy;
        if (descEnd) begin
          offQ[reqSlotQ] <= '0;
          idxQ[reqSlotQ] <= (idxInc == cntQ[reqSlotQ]) ? '0 : idxInc[IDX_W-1:0];
          if (curIoc) doneQ[reqSlotQ] <= 1'b1;
        end else begin
          offQ[reqSlotQ] <= offQ[reqSlotQ] + copy;
        end
      end
      // software writes win over engine updates
      if (regWe) begin
        case (selW)
          SEL_CTL: begin
            if (regWdata[0]) begin
              posQ[regSlot] <= '0; offQ[regSlot] <= '0; idxQ[regSlot] <= '0;
              runQ[regSlot] <= 1'b0; doneQ[regSlot] <= 1'b0;
              loadedQ[regSlot] <= 1'b0; pendQ[regSlot] <= 1'b0;
            end else begin
              tagQ[regSlot] <= regWdata[23:20];
              runQ[regSlot] <= regWdata[1];
              if (regWdata[26]) doneQ[regSlot] <= 1'b0;
              if (regWdata[1] && !runQ[regSlot]) pendQ[regSlot] <= 1'b1;
              if (!regWdata[1] && runQ[regSlot]) begin
                loadedQ[regSlot] <= 1'b0;
                pendQ[regSlot]   <= 1'b0;
              end
            end
          end
          SEL_CBL:     cblQ[regSlot] <= regWdata;
          SEL_LVI:     lviQ[regSlot] <= regWdata[7:0];
          SEL_LIST_LO: listQ[regSlot][31:0]  <= {regWdata[31:7], 7'b0};
          SEL_LIST_HI: listQ[regSlot][63:32] <= regWdata;
          SEL_PBUF_LO: pbufQ[31:0]  <= regWdata;
          SEL_PBUF_HI: pbufQ[63:32] <= regWdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (selW)
      SEL_CTL:     regRdata = {5'b0, doneQ[regSlot], 2'b0, tagQ[regSlot], 18'b0, runQ[regSlot], 1'b0};
      SEL_CBL:     regRdata = cblQ[regSlot];
      SEL_LVI:     regRdata = {24'b0, lviQ[regSlot]};
      SEL_LIST_LO: regRdata = listQ[regSlot][31:0];
      SEL_LIST_HI: regRdata = listQ[regSlot][63:32];
      SEL_POS:     regRdata = posQ[regSlot];
      SEL_PBUF_LO: regRdata = pbufQ[31:0];
      default:     regRdata = pbufQ[63:32];
    endcase
  end

  assign xferMoved = movedQ;
  assign irq       = |doneQ;

  // R7: a completion flag only appears as a result of a burst
  a_r7_done_from_burst: assert property (@(posedge clk) disable iff (!rstN)
    ((doneQ & ~$past(doneQ)) != '0) |-> ($past(stb.segStep) || $past(regWe)));

  // R5: position stays inside the cyclic buffer after a burst
  a_r5_pos_in_range: assert property (@(posedge clk) disable iff (!rstN)
    (stb.segStep && copy != '0 && !regWe && cblQ[reqSlotQ] > posQ[reqSlotQ])
      |=> posQ[$past(reqSlotQ)] < cblQ[$past(reqSlotQ)]);

  // R4: a payload burst never exceeds what is still requested
  a_r4_burst_bounded: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && memData) |-> (memLen <= leftQ && memLen != '0));

endmodule

// File: rtl/sdma_engine.sv
module sdma_engine
  import sdma_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int MAX_DESC  = 4,
  localparam int SLOT_W = $clog2(NUM_SLOTS)
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [SLOT_W-1:0] regSlot,
  input  logic [2:0]        regSel,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  logic              xferValid,
  input  logic [3:0]        xferTag,
  input  logic              xferOut,
  input  logic [31:0]       xferBytes,
  output logic              xferAck,
  output logic [31:0]       xferMoved,
  output logic              memValid,
  output logic              memWrite,
  output logic              memData,
  output logic [63:0]       memAddr,
  output logic [31:0]       memLen,
  output logic [31:0]       memWdata,
  input  logic [31:0]       memRdata,
  output logic              irq
);

  strobe_t stb;
  status_t sts;

  sdma_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .xferValid(xferValid), .sts(sts), .stb(stb)
  );

  sdma_path #(.NUM_SLOTS(NUM_SLOTS), .MAX_DESC(MAX_DESC)) u_path (
    .clk(clk), .rstN(rstN), .stb(stb), .sts(sts),
    .regWe(regWe), .regSlot(regSlot), .regSel(regSel), .regWdata(regWdata),
    .regRdata(regRdata),
    .xferTag(xferTag), .xferOut(xferOut), .xferBytes(xferBytes), .xferMoved(xferMoved),
    .memValid(memValid), .memWrite(memWrite), .memData(memData), .memAddr(memAddr),
    .memLen(memLen), .memWdata(memWdata), .memRdata(memRdata), .irq(irq)
  );

  assign xferAck = stb.ack;

  // R3: nothing reaches memory unless a load or a request is in progress
  a_r3_quiet_when_acking: assert property (@(posedge clk) disable iff (!rstN)
    xferAck |-> !memValid);

endmodule

// File: tb/sdma_engine_test.sv
module sdma_engine_test;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic        regWe = 0;
  logic [2:0]  regSlot = 0, regSel = 0;
  logic [31:0] regWdata = 0, regRdata;
  logic        xferValid = 0, xferOut = 0;
  logic [3:0]  xferTag = 0;
  logic [31:0] xferBytes = 0, xferMoved;
  logic        xferAck, memValid, memWrite, memData, irq;
  logic [63:0] memAddr;
  logic [31:0] memLen, memWdata;
  logic [31:0] memRdata = 0;

  sdma_engine uut (.*);

  int compared = 0, mismatched = 0;

  // bench memory holding descriptor lists
  logic [31:0] descMem [0:255];
  always @(posedge clk)
    if (memValid && !memWrite && !memData) memRdata <= descMem[memAddr[9:2]];

  // reference model
  logic [63:0] mA [8][4];
  int mL [8][4];
  bit mI [8][4];
  int mPos[8], mOff[8], mIdx[8], mN[8], mCbl[8], mTag[8], mLvi[8];
  bit mRun[8], mDone[8];
  logic [63:0] mList[8];
  logic [63:0] mPbuf;

  typedef logic [129:0] cmd_t;
  cmd_t expQ[$];
  string expTag[$];

  task automatic chk(string tag, logic [129:0] act, logic [129:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && memValid) begin
      if (expQ.size() == 0) begin
        compared++; mismatched++;
        $display("FAIL R3 unexpected memory command actual=%h expected=none",
                 {memWrite, memData, memAddr, memLen, memWdata});
      end else begin
        chk(expTag.pop_front(), {memWrite, memData, memAddr, memLen, memWdata}, expQ.pop_front());
      end
    end
  end

  task automatic regWrite(int slot, int sel, logic [31:0] d);
    @(negedge clk);
    regWe = 1; regSlot = slot[2:0]; regSel = sel[2:0]; regWdata = d;
    @(negedge clk);
    regWe = 0;
    case (sel)
      0: begin
        if (d[0]) begin
          mPos[slot] = 0; mOff[slot] = 0; mIdx[slot] = 0; mRun[slot] = 0; mDone[slot] = 0;
        end else begin
          mTag[slot] = d[23:20];
          if (d[26]) mDone[slot] = 0;
          if (d[1] && !mRun[slot]) begin
            mN[slot] = (mLvi[slot] + 1 > 4) ? 4 : mLvi[slot] + 1;
            mIdx[slot] = 0; mOff[slot] = 0;
            for (int e = 0; e < mN[slot]; e++) begin
              for (int w = 0; w < 4; w++) begin
                logic [63:0] a;
                a = mList[slot] + 64'(16 * e + 4 * w);
                expQ.push_back({1'b0, 1'b0, a, 32'd4, 32'd0});
                expTag.push_back("R2 descriptor read");
              end
              mA[slot][e] = {descMem[(mList[slot][9:2]) + 4*e + 1], descMem[(mList[slot][9:2]) + 4*e]};
              mL[slot][e] = descMem[(mList[slot][9:2]) + 4*e + 2];
              mI[slot][e] = descMem[(mList[slot][9:2]) + 4*e + 3][0];
            end
            mRun[slot] = 1;
            repeat (4 * mN[slot] + 4) @(negedge clk);
          end
          mRun[slot] = d[1];
        end
      end
      1: mCbl[slot] = d;
      2: mLvi[slot] = d[7:0];
      3: mList[slot][31:0] = {d[31:7], 7'b0};
      4: mList[slot][63:32] = d;
      6: mPbuf[31:0] = d;
      7: mPbuf[63:32] = d;
      default: ;
    endcase
  endtask

  task automatic readReg(string tag, int slot, int sel, logic [31:0] exp);
    @(negedge clk);
    regSlot = slot[2:0]; regSel = sel[2:0];
    #1;
    chk(tag, {98'b0, regRdata}, {98'b0, exp});
  endtask

  task automatic putDesc(int byteBase, int e, logic [63:0] a, int len, bit ioc);
    descMem[byteBase/4 + 4*e]     = a[31:0];
    descMem[byteBase/4 + 4*e + 1] = a[63:32];
    descMem[byteBase/4 + 4*e + 2] = len;
    descMem[byteBase/4 + 4*e + 3] = {31'b0, ioc};
  endtask

  task automatic doReq(string tag, int t, bit out, int bytes);
    int slot, left, moved, copy, cl, dl;
    bit anyDone;
    slot = -1; moved = 0;
    for (int s = 0; s < 4; s++)
      if (slot < 0 && mTag[(out ? 4 : 0) + s] == t) slot = (out ? 4 : 0) + s;
    if (slot >= 0 && mRun[slot] && !mDone[slot]) begin
      left = bytes;
      while (left > 0) begin
        cl = mCbl[slot] - mPos[slot];
        dl = mL[slot][mIdx[slot]] - mOff[slot];
        copy = left;
        if (cl < copy) copy = cl;
        if (dl < copy) copy = dl;
        if (copy == 0) break;
        expQ.push_back({~out, 1'b1, mA[slot][mIdx[slot]] + 64'(mOff[slot]), 32'(copy), 32'd0});
        expTag.push_back({tag, " burst"});
        mPos[slot] += copy;
        if (mPos[slot] == mCbl[slot]) mPos[slot] = 0;
        mOff[slot] += copy; left -= copy; moved += copy;
        if (mOff[slot] == mL[slot][mIdx[slot]]) begin
          mOff[slot] = 0;
          mIdx[slot] = (mIdx[slot] + 1) % mN[slot];
          if (mI[slot][(mIdx[slot] + mN[slot] - 1) % mN[slot]]) begin
            mDone[slot] = 1;
            break;
          end
        end
      end
      if (mPbuf[0]) begin
        expQ.push_back({1'b1, 1'b0, {mPbuf[63:1], 1'b0} + 64'(8 * slot), 32'd4, 32'(mPos[slot])});
        expTag.push_back("R9 position write");
      end
    end
    @(negedge clk);
    xferValid = 1; xferTag = t[3:0]; xferOut = out; xferBytes = bytes;
    do @(negedge clk); while (!xferAck);
    xferValid = 0;
    chk({tag, " moved (R12)"}, {98'b0, xferMoved}, {98'b0, 32'(moved)});
    anyDone = 0;
    for (int s = 0; s < 8; s++) anyDone |= mDone[s];
    chk({tag, " irq"}, {129'b0, irq}, {129'b0, anyDone});
    @(negedge clk);
    chk({tag, " no leftover commands (R3)"}, 130'(expQ.size()), 130'd0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) descMem[i] = 0;
    for (int s = 0; s < 8; s++) begin
      mPos[s] = 0; mOff[s] = 0; mIdx[s] = 0; mN[s] = 0; mCbl[s] = 0; mTag[s] = 0;
      mLvi[s] = 0; mRun[s] = 0; mDone[s] = 0; mList[s] = 0;
    end
    mPbuf = 0;
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", {129'b0, irq}, 130'd0);
    chk("R1 memValid", {129'b0, memValid}, 130'd0);
    chk("R1 xferAck", {129'b0, xferAck}, 130'd0);
    readReg("R1 ctl slot0", 0, 0, 0);
    readReg("R1 pos slot5", 5, 5, 0);

    // output slot 5: three entries, list base written misaligned (R2)
    putDesc(32'h100, 0, 64'h10000, 300, 0);
    putDesc(32'h100, 1, 64'h20000, 200, 1);
    putDesc(32'h100, 2, 64'h30000, 600, 0);
    regWrite(5, 1, 1000);
    regWrite(5, 2, 2);
    regWrite(5, 3, 32'h135);
    regWrite(5, 4, 0);
    regWrite(5, 0, (3 << 20) | 2);
    // output slot 7 shares the tag (R3 lowest slot wins)
    putDesc(32'h300, 0, 64'h70000, 100, 0);
    regWrite(7, 1, 1000);
    regWrite(7, 2, 0);
    regWrite(7, 3, 32'h300);
    regWrite(7, 0, (3 << 20) | 2);
    // input slot 1: one 64-byte entry, 64-byte cyclic buffer
    putDesc(32'h200, 0, 64'h40000, 64, 0);
    regWrite(1, 1, 64);
    regWrite(1, 2, 0);
    regWrite(1, 3, 32'h200);
    regWrite(1, 0, (3 << 20) | 2);

    doReq("R4 plain burst", 3, 1, 250);
    doReq("R7 ioc stall", 3, 1, 400);
    readReg("R7 ctl done bit", 5, 0, (1 << 26) | (3 << 20) | 2);
    doReq("R8 stalled request", 3, 1, 100);
    regWrite(5, 0, (1 << 26) | (3 << 20) | 2);
    readReg("R8 ctl cleared", 5, 0, (3 << 20) | 2);
    chk("R8 irq low", {129'b0, irq}, 130'd0);

    regWrite(0, 6, 32'h5001);
    regWrite(0, 7, 0);
    doReq("R5 R6 wrap", 3, 1, 600);
    readReg("R5 pos slot5", 5, 5, 100);
    doReq("R4 input burst", 3, 0, 48);
    doReq("R5 input wrap", 3, 0, 40);
    readReg("R5 pos slot1", 1, 5, 24);

    regWrite(4, 0, 7 << 20);
    doReq("R3 no match in input group", 7, 0, 32);
    doReq("R3 matched slot not running", 7, 1, 32);

    regWrite(5, 0, 3 << 20);
    doReq("R11 stopped slot", 3, 1, 50);

    regWrite(1, 0, 1);
    readReg("R10 pos cleared", 1, 5, 0);
    readReg("R10 ctl after reset", 1, 0, 3 << 20);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    compared++; mismatched++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule